// File: doc/BRIEF.md
# VGA Scan-Out Timing and Pixel Stage

This block produces horizontal and vertical sync, a display-enable flag and 5-6-5 colour for a video DAC. It runs on a fast system clock, and a one-cycle pixel-enable strobe sets the pixel rate inside that clock. While the beam is in the visible area, the block takes one 16-bit pixel from an external FIFO on each pixel-enable cycle and splits it into red, green and blue. Everywhere else it drives the colour outputs to zero, so the DAC needs no separate blanking input.

A processor writes the line and frame geometry through a small write port. Each axis has four values: visible length, front porch, sync width and back porch. A write lands in a staging copy, and that copy moves into the live set only when a frame wraps, so a mode change never tears a frame. A one-cycle trigger marks the start of the first front-porch line, which gives a memory fetcher the whole vertical border to refill the FIFO before the next frame. If the FIFO is empty during a visible pixel, that pixel is black and an underflow pulse is raised.

Top module: `vga_scan_out`

## Requirements
- R1: While reset is held, and until the first pixel enable after it, `vid_hsync_n` and `vid_vsync_n` are 1. `vid_de`, all colour bits, `vid_underflow`, `frame_trig` and `fifo_pop` are 0.
- R2: Sync, enable and colour outputs change only in the cycle after a clock edge on which `pix_en` was 1. After any other edge they hold their values.
- R3: Horizontal position counts pixel enables from 0. The first A positions are visible, the next F are front porch, the next S drive `vid_hsync_n` low, and the last B are back porch. A line is A+F+S+B pixels. Each output shows the position sampled at the preceding pixel enable.
- R4: Vertical position counts lines with the same four-part layout. It advances when a line ends, and `vid_vsync_n` is low during the S sync lines.
- R5: `vid_de` is 1 only for pixels that are visible on both axes. A popped word d gives red = d[15:11], green = d[10:5] and blue = d[4:0].
- R6: Whenever `vid_de` is 0, all colour outputs are 0.
- R7: `fifo_pop` is 1, in the same cycle, exactly when `pix_en` is 1, the current position is visible and `fifo_empty` is 0.
- R8: A visible pixel enable that meets `fifo_empty`=1 produces black colour with `vid_de`=1, and `vid_underflow` is 1 for exactly the following cycle.
- R9: `frame_trig` is 1 for one cycle, right after the pixel enable that ends the last visible line, which is when the first front-porch line begins.
- R10: A write with `cfg_we`=1 stores `cfg_wdata` into the staging register chosen by `cfg_sel`: 0 h-visible, 1 h-front, 2 h-sync, 3 h-back, 4 v-visible, 5 v-front, 6 v-sync, 7 v-back. All staged values become live on the pixel enable that ends a frame. A write on that same edge becomes live one frame later.
- R11: After reset, the live and staged values equal the parameter defaults. The defaults give 640x480 with 800 clocks per line (96 sync, 48 back, 16 front) and 525 lines (2 sync, 33 back, 10 front).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | One-cycle pixel-rate strobe |
| cfg_we | input | 1 | Geometry register write strobe |
| cfg_sel | input | 3 | Geometry register select |
| cfg_wdata | input | CW | Geometry write value |
| fifo_empty | input | 1 | Pixel FIFO has no data |
| fifo_data | input | 16 | Pixel FIFO head word, 5-6-5 packed |
| fifo_pop | output | 1 | Take the FIFO head word this cycle |
| vid_hsync_n | output | 1 | Horizontal sync, active low |
| vid_vsync_n | output | 1 | Vertical sync, active low |
| vid_de | output | 1 | Visible-area flag |
| vid_red | output | 5 | Red to DAC |
| vid_grn | output | 6 | Green to DAC |
| vid_blu | output | 5 | Blue to DAC |
| vid_underflow | output | 1 | Visible pixel found the FIFO empty |
| frame_trig | output | 1 | Start of first front-porch line |

## Verification
A geometry write and the frame wrap can fall on the same pixel enable. The staging update and the commit then act on the same registers in one cycle. The bench follows its reference model to the exact step that wraps a frame, issues a new h-visible write on that edge, and then checks sync and enable timing over the next two frames. The first of those frames must still use the old value, and only the second may use the new one. A FIFO starvation run across visible pixels also checks that underflow and the zero-colour rule are applied together on the same pixel.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  localparam int NUM_TREG = 8;

  typedef enum logic [2:0] {
    TSEL_H_VIS   = 3'd0,
    TSEL_H_FRONT = 3'd1,
    TSEL_H_SYNC  = 3'd2,
    TSEL_H_BACK  = 3'd3,
    TSEL_V_VIS   = 3'd4,
    TSEL_V_FRONT = 3'd5,
    TSEL_V_SYNC  = 3'd6,
    TSEL_V_BACK  = 3'd7
  } tsel_e;

  typedef struct packed {
    logic [4:0] red;
    logic [5:0] grn;
    logic [4:0] blu;
  } rgb565_t;

endpackage

// File: rtl/vga_timing_regs.sv
module vga_timing_regs
  import vga_scan_pkg::*;
#(
  parameter int CW      = 11,
  parameter int H_ACT   = 640,
  parameter int H_FRONT = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int V_ACT   = 480,
  parameter int V_FRONT = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 33
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  tsel_e                         wr_sel,
  input  logic [CW-1:0]                 wr_data,
  input  logic                          commit,
  output logic [NUM_TREG-1:0][CW-1:0]   live_o
);

  localparam logic [NUM_TREG-1:0][CW-1:0] DEFAULTS = {
    CW'(V_BACK), CW'(V_SYNC), CW'(V_FRONT), CW'(V_ACT),
    CW'(H_BACK), CW'(H_SYNC), CW'(H_FRONT), CW'(H_ACT)
  };

  for (genvar i = 0; i < NUM_TREG; i++) begin : g_treg
    logic [CW-1:0] stage_q, stage_d;
    logic [CW-1:0] live_q, live_d;
    logic          hit;

    always_comb begin
      hit     = wr_en && (wr_sel == tsel_e'(i));
      stage_d = hit ? wr_data : stage_q;
      // commit copies the value staged before this edge
      live_d  = commit ? stage_q : live_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= DEFAULTS[i];
        live_q  <= DEFAULTS[i];
      end else begin
        stage_q <= stage_d;
        live_q  <= live_d;
      end
    end

    assign live_o[i] = live_q;
  end

endmodule

// File: rtl/vga_axis_counter.sv
module vga_axis_counter #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] len_vis,
  input  logic [CW-1:0] len_front,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_back,
  output logic [CW-1:0] pos,
  output logic          in_vis,
  output logic          in_sync,
  output logic          at_last
);

  localparam int SW = CW + 2;

  logic [CW-1:0] pos_q, pos_d;
  logic [SW-1:0] pos_x, sync_lo, sync_hi, total;

  always_comb begin
    pos_x   = SW'(pos_q);
    sync_lo = SW'(len_vis) + SW'(len_front);
    sync_hi = sync_lo + SW'(len_sync);
    total   = sync_hi + SW'(len_back);
    in_vis  = pos_x < SW'(len_vis);
    in_sync = (pos_x >= sync_lo) && (pos_x < sync_hi);
    at_last = pos_x == (total - SW'(1));
    pos_d   = pos_q;
    if (step) begin
      pos_d = at_last ? '0 : pos_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_d;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/vga_pixel_out.sv
module vga_pixel_out
  import vga_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_en,
  input  logic        h_vis,
  input  logic        v_vis,
  input  logic        h_sync,
  input  logic        v_sync,
  input  logic        frame_edge,
  input  logic        fifo_empty,
  input  logic [15:0] fifo_data,
  output logic        fifo_pop,
  output logic        hsync_n,
  output logic        vsync_n,
  output logic        de,
  output rgb565_t     rgb,
  output logic        underflow,
  output logic        trig
);

  logic    area;
  logic    hs_q, hs_d, vs_q, vs_d, de_q, de_d;
  logic    uf_q, uf_d, tr_q, tr_d;
  rgb565_t rgb_q, rgb_d;

  always_comb begin
    area     = h_vis && v_vis;
    fifo_pop = pix_en && area && !fifo_empty;
    hs_d     = hs_q;
    vs_d     = vs_q;
    de_d     = de_q;
    rgb_d    = rgb_q;
    if (pix_en) begin
      hs_d  = !h_sync;
      vs_d  = !v_sync;
      de_d  = area;
      rgb_d = fifo_pop ? rgb565_t'(fifo_data) : '0;
    end
    uf_d = pix_en && area && fifo_empty;
    tr_d = frame_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
      de_q  <= 1'b0;
      rgb_q <= '0;
      uf_q  <= 1'b0;
      tr_q  <= 1'b0;
    end else begin
      hs_q  <= hs_d;
      vs_q  <= vs_d;
      de_q  <= de_d;
      rgb_q <= rgb_d;
      uf_q  <= uf_d;
      tr_q  <= tr_d;
    end
  end

  assign hsync_n   = hs_q;
  assign vsync_n   = vs_q;
  assign de        = de_q;
  assign rgb       = rgb_q;
  assign underflow = uf_q;
  assign trig      = tr_q;

endmodule

// File: rtl/vga_scan_out.sv
module vga_scan_out
  import vga_scan_pkg::*;
#(
  parameter int CW      = 11,
  parameter int H_ACT   = 640,
  parameter int H_FRONT = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int V_ACT   = 480,
  parameter int V_FRONT = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          fifo_empty,
  input  logic [15:0]   fifo_data,
  output logic          fifo_pop,
  output logic          vid_hsync_n,
  output logic          vid_vsync_n,
  output logic          vid_de,
  output logic [4:0]    vid_red,
  output logic [5:0]    vid_grn,
  output logic [4:0]    vid_blu,
  output logic          vid_underflow,
  output logic          frame_trig
);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_TREG-1:0][CW-1:0] live;
  logic                        commit;

  vga_timing_regs #(
    .CW(CW), .H_ACT(H_ACT), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACT(V_ACT), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_sel  (tsel_e'(cfg_sel)),
    .wr_data (cfg_wdata),
    .commit  (commit),
    .live_o  (live)
  );

  logic [CW-1:0] h_pos, v_pos;
  logic          h_vis, h_sync, h_last;
  logic          v_vis, v_sync, v_last;
  logic          v_step, frame_edge;

  vga_axis_counter #(.CW(CW)) u_hcnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (pix_en),
    .len_vis   (live[TSEL_H_VIS]),
    .len_front (live[TSEL_H_FRONT]),
    .len_sync  (live[TSEL_H_SYNC]),
    .len_back  (live[TSEL_H_BACK]),
    .pos       (h_pos),
    .in_vis    (h_vis),
    .in_sync   (h_sync),
    .at_last   (h_last)
  );

  vga_axis_counter #(.CW(CW)) u_vcnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (v_step),
    .len_vis   (live[TSEL_V_VIS]),
    .len_front (live[TSEL_V_FRONT]),
    .len_sync  (live[TSEL_V_SYNC]),
    .len_back  (live[TSEL_V_BACK]),
    .pos       (v_pos),
    .in_vis    (v_vis),
    .in_sync   (v_sync),
    .at_last   (v_last)
  );

  always_comb begin
    v_step     = pix_en && h_last;
    commit     = v_step && v_last;
    frame_edge = v_step && (v_pos == (live[TSEL_V_VIS] - CW'(1)));
  end

  rgb565_t rgb;

  vga_pixel_out u_pix (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pix_en     (pix_en),
    .h_vis      (h_vis),
    .v_vis      (v_vis),
    .h_sync     (h_sync),
    .v_sync     (v_sync),
    .frame_edge (frame_edge),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .fifo_pop   (fifo_pop),
    .hsync_n    (vid_hsync_n),
    .vsync_n    (vid_vsync_n),
    .de         (vid_de),
    .rgb        (rgb),
    .underflow  (vid_underflow),
    .trig       (frame_trig)
  );

  assign vid_red = rgb.red;
  assign vid_grn = rgb.grn;
  assign vid_blu = rgb.blu;

endmodule

// File: rtl/vga_scan_out_chk.sv
module vga_scan_out_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          pix_en,
  input logic          fifo_empty,
  input logic          fifo_pop,
  input logic          vid_hsync_n,
  input logic          vid_vsync_n,
  input logic          vid_de,
  input logic [4:0]    vid_red,
  input logic [5:0]    vid_grn,
  input logic [4:0]    vid_blu,
  input logic          vid_underflow,
  input logic          frame_trig,
  input logic [CW-1:0] h_pos
);

  // R6
  black_outside_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !vid_de |-> (vid_red == '0 && vid_grn == '0 && vid_blu == '0));

  // R8
  underflow_black_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    vid_underflow |-> (vid_de && vid_red == '0 && vid_grn == '0 && vid_blu == '0));

  // R7
  pop_qualified_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    fifo_pop |-> (pix_en && !fifo_empty));

  // R9
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    frame_trig |=> !frame_trig);

  // R2
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !pix_en |=> ($stable(vid_hsync_n) && $stable(vid_vsync_n) && $stable(vid_de)
                 && $stable(vid_red) && $stable(vid_grn) && $stable(vid_blu)));

  // R3
  hpos_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !pix_en |=> $stable(h_pos));

endmodule

bind vga_scan_out vga_scan_out_chk #(.CW(CW)) u_chk (
  .clk           (clk),
  .rst_ok        (rst_sync_n),
  .pix_en        (pix_en),
  .fifo_empty    (fifo_empty),
  .fifo_pop      (fifo_pop),
  .vid_hsync_n   (vid_hsync_n),
  .vid_vsync_n   (vid_vsync_n),
  .vid_de        (vid_de),
  .vid_red       (vid_red),
  .vid_grn       (vid_grn),
  .vid_blu       (vid_blu),
  .vid_underflow (vid_underflow),
  .frame_trig    (frame_trig),
  .h_pos         (h_pos)
);

// File: tb/tb_vga_scan_out.sv
`timescale 1ns/1ps
module tb_vga_scan_out;

  localparam int CW = 11;
  // small geometry so whole frames fit in a short run
  localparam int P_HA = 4, P_HF = 2, P_HS = 3, P_HB = 1;
  localparam int P_VA = 3, P_VF = 1, P_VS = 2, P_VB = 1;

  typedef struct packed {
    logic       hs;
    logic       vs;
    logic       de;
    logic [4:0] r;
    logic [5:0] g;
    logic [4:0] b;
    logic       uf;
    logic       tr;
  } obs_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pix_en, cfg_we, fifo_empty;
  logic [2:0]    cfg_sel;
  logic [CW-1:0] cfg_wdata;
  logic [15:0]   fifo_data;
  logic          fifo_pop, vid_hsync_n, vid_vsync_n, vid_de, vid_underflow, frame_trig;
  logic [4:0]    vid_red, vid_blu;
  logic [5:0]    vid_grn;

  always #4 clk = ~clk;

  vga_scan_out #(
    .CW(CW), .H_ACT(P_HA), .H_FRONT(P_HF), .H_SYNC(P_HS), .H_BACK(P_HB),
    .V_ACT(P_VA), .V_FRONT(P_VF), .V_SYNC(P_VS), .V_BACK(P_VB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .vid_hsync_n(vid_hsync_n), .vid_vsync_n(vid_vsync_n),
    .vid_de(vid_de), .vid_red(vid_red), .vid_grn(vid_grn), .vid_blu(vid_blu),
    .vid_underflow(vid_underflow), .frame_trig(frame_trig)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  obs_t        exp_q[$];
  string       ctx_q[$];
  logic [15:0] fq[$];
  logic [15:0] seed = 16'h1234;
  bit          starve = 0;
  string       ctx = "R11";

  int   live[8];
  int   stage[8];
  int   mh = 0, mv = 0;
  obs_t cur;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, want, $time);
    end
  endtask

  function automatic int htot();
    return live[0] + live[1] + live[2] + live[3];
  endfunction
  function automatic int vtot();
    return live[4] + live[5] + live[6] + live[7];
  endfunction

  // one clock of stimulus with reference prediction pushed to the scoreboard
  task automatic step(input bit pe, input bit we = 0, input int sel = 0, input int wd = 0);
    bit          act, empty, pop, hl, vl;
    logic [15:0] d;
    obs_t        n;
    @(negedge clk);
    while (!starve && fq.size() < 3) begin
      fq.push_back(seed);
      seed = seed * 16'd25173 + 16'd13849;
    end
    empty = starve || (fq.size() == 0);
    d = (fq.size() > 0) ? fq[0] : 16'h0;
    pix_en = pe; cfg_we = we; cfg_sel = sel[2:0]; cfg_wdata = wd[CW-1:0];
    fifo_empty = empty; fifo_data = d;
    #1;
    act = (mh < live[0]) && (mv < live[4]);
    pop = pe && act && !empty;
    chk("R7 pop", {15'd0, fifo_pop}, {15'd0, pop});
    n = cur; n.uf = 1'b0; n.tr = 1'b0;
    if (pe) begin
      n.hs = !((mh >= live[0] + live[1]) && (mh < live[0] + live[1] + live[2]));
      n.vs = !((mv >= live[4] + live[5]) && (mv < live[4] + live[5] + live[6]));
      n.de = act;
      n.r  = pop ? d[15:11] : 5'd0;
      n.g  = pop ? d[10:5]  : 6'd0;
      n.b  = pop ? d[4:0]   : 5'd0;
      n.uf = act && empty;
      hl = (mh == htot() - 1);
      vl = (mv == vtot() - 1);
      n.tr = hl && (mv == live[4] - 1);
      if (hl) begin
        mh = 0;
        if (vl) begin
          mv = 0;
          for (int i = 0; i < 8; i++) live[i] = stage[i];
        end else begin
          mv = mv + 1;
        end
      end else begin
        mh = mh + 1;
      end
    end
    if (we) stage[sel] = wd;
    cur = n;
    exp_q.push_back(n);
    ctx_q.push_back(pe ? ctx : "R2");
    @(posedge clk);
    #1;
    if (pop) void'(fq.pop_front());
    pix_en = 1'b0; cfg_we = 1'b0;
  endtask

  // monitor: compare registered outputs one cycle after each prediction
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      obs_t  e;
      string c;
      e = exp_q.pop_front();
      c = ctx_q.pop_front();
      chk({"R3 hsync ", c}, {15'd0, vid_hsync_n}, {15'd0, e.hs});
      chk({"R4 vsync ", c}, {15'd0, vid_vsync_n}, {15'd0, e.vs});
      chk({"R5 de ", c}, {15'd0, vid_de}, {15'd0, e.de});
      chk({e.de ? "R5 rgb " : "R6 rgb ", c}, {vid_red, vid_grn, vid_blu}, {e.r, e.g, e.b});
      chk({"R8 underflow ", c}, {15'd0, vid_underflow}, {15'd0, e.uf});
      chk({"R9 trig ", c}, {15'd0, frame_trig}, {15'd0, e.tr});
    end
  end

  task automatic run_pixels(input int count, input bit every);
    for (int k = 0; k < count; k++) begin
      step(1'b1);
      if (!every) step(1'b0);
    end
  endtask

  task automatic check_r1();
    chk("R1 hsync", {15'd0, vid_hsync_n}, 16'd1);
    chk("R1 vsync", {15'd0, vid_vsync_n}, 16'd1);
    chk("R1 de", {15'd0, vid_de}, 16'd0);
    chk("R1 rgb", {vid_red, vid_grn, vid_blu}, 16'd0);
    chk("R1 underflow", {15'd0, vid_underflow}, 16'd0);
    chk("R1 trig", {15'd0, frame_trig}, 16'd0);
    chk("R1 pop", {15'd0, fifo_pop}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    live  = '{P_HA, P_HF, P_HS, P_HB, P_VA, P_VF, P_VS, P_VB};
    stage = live;
    cur = '{hs: 1'b1, vs: 1'b1, de: 1'b0, r: 5'd0, g: 6'd0, b: 5'd0, uf: 1'b0, tr: 1'b0};
    rst_n = 1'b0; pix_en = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    fifo_empty = 1'b1; fifo_data = '0;
    repeat (3) @(negedge clk);
    check_r1();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check_r1();

    // R11: default geometry from parameters, strobe every other clock
    ctx = "R11";
    run_pixels(2 * 70, 1'b0);

    // R8: starve the FIFO for a whole frame
    ctx = "R8";
    starve = 1;
    run_pixels(70, 1'b1);
    starve = 0;

    // R10: stage a new geometry mid-frame while idle, then run on
    ctx = "R10";
    run_pixels(23, 1'b1);
    step(1'b0, 1'b1, 0, 5);
    step(1'b0, 1'b1, 1, 1);
    step(1'b0, 1'b1, 2, 2);
    step(1'b0, 1'b1, 3, 2);
    step(1'b0, 1'b1, 4, 2);
    step(1'b0, 1'b1, 5, 2);
    step(1'b0, 1'b1, 6, 1);
    step(1'b0, 1'b1, 7, 2);
    run_pixels(47 + 2 * 70, 1'b1);

    // R10: write landing on the frame-wrap edge is deferred one frame
    run_pixels(13, 1'b1);
    while (!((mh == htot() - 1) && (mv == vtot() - 1))) step(1'b1);
    step(1'b1, 1'b1, 0, 6);
    run_pixels(2 * htot() * vtot() + 30, 1'b1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule